// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block works next to a small 8-bit microcontroller core. Once per idle cycle it decides whether an interrupt may be taken now. Its inputs are a reset request, a mask of pending hardware sources, the global interrupt-enable flag, a flag that marks a pending conditional skip, the current word program counter and the stack pointer.

When it accepts a request, the block stalls the core and writes the return program counter to the stack through a byte-wide memory write port, one byte per cycle. It then delivers a single vector cycle. That cycle carries the new program counter and the new stack pointer. In the same cycle it tells the core to clear the global enable flag and it acknowledges the source it served.

Two settings are read only while reset is asserted and are held afterwards. The first is the width of the return address, 1, 2 or 3 bytes. The second is the vector slot size, 1 or 2 words.

Top module: `irq_entry_seq`

## Requirements
- R1: No request is accepted, including a reset request, while `skip_pend` is high. In that case `taken`, `stall` and `mem_we` stay low.
- R2: No request is accepted while `gie` is low. A reset request is accepted only with `gie` high, wins over any pending hardware source, and uses vector number 0.
- R3: If there is no reset request, the served hardware source is the lowest-numbered set bit of `pend_src`. Source index n uses vector number n+1.
- R4: `pc_new` equals the vector number times the slot size. The slot size is 2 words when `cfg_long_slot` is 1 and 1 word when it is 0, and the table starts at address 0.
- R5: The return PC is written least significant byte first. The writes go to addresses `sp_cur`, `sp_cur`-1 and `sp_cur`-2 (modulo 2^SP_W), one byte per cycle. `mem_we` is high for exactly one cycle per byte, and those cycles follow each other.
- R6: The byte count is 3 when `cfg_pc_bytes` is 3, 2 when it is 2, and 1 for any other value. `sp_new` equals `sp_cur` minus that count.
- R7: The cycle after the last write is the vector cycle. In that cycle `pc_load`, `sp_load` and `gie_clr` are each high for exactly one cycle, and `mem_we` is low.
- R8: In the vector cycle, `src_ack` is one-hot on the served source bit for a hardware entry and zero for a reset entry. `reset_ack` is high only for a reset entry. `req_drop` is high only when the served bit was the only set bit.
- R9: `taken` is high for one cycle, which is the cycle of the first write. `stall` is high from the first write through the vector cycle and low otherwise.
- R10: `cfg_pc_bytes` and `cfg_long_slot` are captured only while `rst` is high. Changes to them after reset have no effect.
- R11: While `rst` is high and directly after it, every strobe, `stall` and `src_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also captures configuration |
| cfg_pc_bytes | input | 2 | Return-address byte count (3, 2, else 1) |
| cfg_long_slot | input | 1 | 1: two-word vector slots, 0: one-word |
| reset_req | input | 1 | Reset request |
| pend_src | input | SRC_W | Pending hardware sources, bit n = source n |
| gie | input | 1 | Global interrupt enable |
| skip_pend | input | 1 | Conditional skip pending in the core |
| pc_cur | input | PC_W | Current word program counter |
| sp_cur | input | SP_W | Current stack pointer |
| taken | output | 1 | One-cycle acceptance pulse |
| stall | output | 1 | Holds the core during entry |
| mem_we | output | 1 | Stack byte write strobe |
| mem_addr | output | SP_W | Stack write address |
| mem_wdata | output | 8 | Stack write data |
| pc_load | output | 1 | Load `pc_new` into the PC |
| pc_new | output | PC_W | Vector address |
| sp_load | output | 1 | Load `sp_new` into the SP |
| sp_new | output | SP_W | Stack pointer after the pushes |
| gie_clr | output | 1 | Clear the global enable flag |
| src_ack | output | SRC_W | One-hot clear of the served source |
| reset_ack | output | 1 | Reset request served |
| req_drop | output | 1 | No hardware source remains after this one |

## Verification
The embedded assertions check these rules on every cycle: no acceptance while a skip is pending, consecutive stack writes at addresses that step down by one, `taken` always together with a write, a one-hot acknowledge, and the vector cycle ending the stall. The bench scenarios are the only way to show the data-dependent results: which source wins, the vector arithmetic for both slot sizes, the byte order and count for each width setting, stack-pointer wrap, and the fact that configuration is ignored after reset.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH0,
    ST_PUSH1,
    ST_PUSH2,
    ST_VECTOR
  } seq_state_t;

  // Map the configuration code to a byte count: 3 -> 3, 2 -> 2, else 1.
  function automatic logic [1:0] decode_nbytes(input logic [1:0] code);
    case (code)
      2'd3:    decode_nbytes = 2'd3;
      2'd2:    decode_nbytes = 2'd2;
      default: decode_nbytes = 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int SRC_W = 8,
  localparam int IDX_W = (SRC_W > 1) ? $clog2(SRC_W) : 1
) (
  input  logic [SRC_W-1:0] req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [SRC_W-1:0] onehot,
  output logic             only
);
  // Prefix OR of the lower bits: a bit wins when nothing below it is set.
  logic [SRC_W:0] below;
  assign below[0] = 1'b0;

  for (genvar g = 0; g < SRC_W; g++) begin : g_bit
    assign onehot[g]  = req[g] & ~below[g];
    assign below[g+1] = below[g] | req[g];
  end

  assign any  = below[SRC_W];
  assign only = any && ((req & ~onehot) == '0);

  always_comb begin
    idx = '0;
    for (int i = SRC_W - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_vec_calc.sv
module irq_vec_calc #(
  parameter int SRC_W = 8,
  parameter int PC_W  = 22,
  localparam int IDX_W = (SRC_W > 1) ? $clog2(SRC_W) : 1
) (
  input  logic             is_reset,
  input  logic [IDX_W-1:0] idx,
  input  logic             long_slot,
  output logic [PC_W-1:0]  vec_pc
);
  logic [PC_W-1:0] vec_num;

  always_comb begin
    vec_num = is_reset ? '0 : (PC_W'(idx) + PC_W'(1));
    vec_pc  = long_slot ? (vec_num << 1) : vec_num;
  end
endmodule

// File: rtl/irq_push_mux.sv
module irq_push_mux #(
  parameter int PC_W = 22,
  localparam int NB = 3
) (
  input  logic [PC_W-1:0] ret_pc,
  input  logic [1:0]      sel,
  output logic [7:0]      data
);
  logic [8*NB-1:0] padded;
  logic [7:0]      lane [NB];

  assign padded = (8*NB)'(ret_pc);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign lane[b] = padded[8*b +: 8];
  end

  always_comb begin
    case (sel)
      2'd1:    data = lane[1];
      2'd2:    data = lane[2];
      default: data = lane[0];
    endcase
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int SRC_W = 8,
  parameter int PC_W  = 22,
  parameter int SP_W  = 16,
  localparam int IDX_W = (SRC_W > 1) ? $clog2(SRC_W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_pc_bytes,
  input  logic             cfg_long_slot,
  input  logic             reset_req,
  input  logic [SRC_W-1:0] pend_src,
  input  logic             gie,
  input  logic             skip_pend,
  input  logic [PC_W-1:0]  pc_cur,
  input  logic [SP_W-1:0]  sp_cur,
  output logic             taken,
  output logic             stall,
  output logic             mem_we,
  output logic [SP_W-1:0]  mem_addr,
  output logic [7:0]       mem_wdata,
  output logic             pc_load,
  output logic [PC_W-1:0]  pc_new,
  output logic             sp_load,
  output logic [SP_W-1:0]  sp_new,
  output logic             gie_clr,
  output logic [SRC_W-1:0] src_ack,
  output logic             reset_ack,
  output logic             req_drop
);
  seq_state_t       state;
  logic [1:0]       nb_q;
  logic             long_q;
  logic [PC_W-1:0]  ret_q;
  logic [SP_W-1:0]  sp_q;
  logic             is_rst_q;
  logic [IDX_W-1:0] idx_q;
  logic [SRC_W-1:0] ack_q;
  logic             last_q;

  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;
  logic [SRC_W-1:0] pick_onehot;
  logic             pick_only;
  logic [PC_W-1:0]  vec_pc;
  logic [7:0]       next_byte;
  logic [1:0]       byte_sel;
  logic             accept;

  irq_pick #(.SRC_W(SRC_W)) u_pick (
    .req    (pend_src),
    .any    (pick_any),
    .idx    (pick_idx),
    .onehot (pick_onehot),
    .only   (pick_only)
  );

  irq_vec_calc #(.SRC_W(SRC_W), .PC_W(PC_W)) u_vec (
    .is_reset  (is_rst_q),
    .idx       (idx_q),
    .long_slot (long_q),
    .vec_pc    (vec_pc)
  );

  assign byte_sel = (state == ST_PUSH0) ? 2'd1 : 2'd2;

  irq_push_mux #(.PC_W(PC_W)) u_mux (
    .ret_pc (ret_q),
    .sel    (byte_sel),
    .data   (next_byte)
  );

  assign accept = (state == ST_IDLE) && !skip_pend && gie && (reset_req || pick_any);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      nb_q      <= decode_nbytes(cfg_pc_bytes);
      long_q    <= cfg_long_slot;
      ret_q     <= '0;
      sp_q      <= '0;
      is_rst_q  <= 1'b0;
      idx_q     <= '0;
      ack_q     <= '0;
      last_q    <= 1'b0;
      taken     <= 1'b0;
      stall     <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      pc_load   <= 1'b0;
      pc_new    <= '0;
      sp_load   <= 1'b0;
      sp_new    <= '0;
      gie_clr   <= 1'b0;
      src_ack   <= '0;
      reset_ack <= 1'b0;
      req_drop  <= 1'b0;
    end else begin
      taken     <= 1'b0;
      mem_we    <= 1'b0;
      pc_load   <= 1'b0;
      sp_load   <= 1'b0;
      gie_clr   <= 1'b0;
      src_ack   <= '0;
      reset_ack <= 1'b0;
      req_drop  <= 1'b0;
      case (state)
        ST_IDLE: begin
          stall <= 1'b0;
          if (accept) begin
            ret_q     <= pc_cur;
            sp_q      <= sp_cur;
            is_rst_q  <= reset_req;
            idx_q     <= pick_idx;
            ack_q     <= pick_onehot;
            last_q    <= pick_only;
            state     <= ST_PUSH0;
            taken     <= 1'b1;
            stall     <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= sp_cur;
            mem_wdata <= pc_cur[7:0];
          end
        end
        ST_PUSH0, ST_PUSH1: begin
          if ((state == ST_PUSH0 && nb_q >= 2'd2) || (state == ST_PUSH1 && nb_q == 2'd3)) begin
            state     <= (state == ST_PUSH0) ? ST_PUSH1 : ST_PUSH2;
            mem_we    <= 1'b1;
            mem_addr  <= mem_addr - SP_W'(1);
            mem_wdata <= next_byte;
          end else begin
            state     <= ST_VECTOR;
            pc_load   <= 1'b1;
            pc_new    <= vec_pc;
            sp_load   <= 1'b1;
            sp_new    <= sp_q - SP_W'(nb_q);
            gie_clr   <= 1'b1;
            src_ack   <= is_rst_q ? '0 : ack_q;
            reset_ack <= is_rst_q;
            req_drop  <= !is_rst_q && last_q;
          end
        end
        ST_PUSH2: begin
          state     <= ST_VECTOR;
          pc_load   <= 1'b1;
          pc_new    <= vec_pc;
          sp_load   <= 1'b1;
          sp_new    <= sp_q - SP_W'(nb_q);
          gie_clr   <= 1'b1;
          src_ack   <= is_rst_q ? '0 : ack_q;
          reset_ack <= is_rst_q;
          req_drop  <= !is_rst_q && last_q;
        end
        ST_VECTOR: begin
          state <= ST_IDLE;
          stall <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: a pending skip in an idle cycle must not produce an acceptance.
  a_r1_skip_holds_off: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && skip_pend) |=> !taken);

  // R2: nothing is accepted with the global enable low.
  a_r2_gie_gates: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !gie) |=> !taken);

  // R5: back-to-back pushes step the address down by one.
  a_r5_addr_steps_down: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - SP_W'(1)));

  // R7: the vector cycle carries no write and clears the enable.
  a_r7_vector_cycle: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> (gie_clr && sp_load && !mem_we));

  // R8: at most one source is acknowledged, never together with a reset entry.
  a_r8_ack_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_ack) && !(reset_ack && (src_ack != '0)));

  // R9: acceptance coincides with the first write and the stall; stall ends after vector.
  a_r9_taken_first_write: assert property (@(posedge clk) disable iff (rst)
    taken |-> (mem_we && stall));
  a_r9_stall_release: assert property (@(posedge clk) disable iff (rst)
    pc_load |=> !stall);
endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
  localparam int SRC_W = 8;
  localparam int PC_W  = 22;
  localparam int SP_W  = 16;
  localparam int NV    = 6;

  // Table: cfg code, long slot, reset request, pending mask, pc, sp.
  localparam logic [1:0]       T_CFG  [NV] = '{2'd3, 2'd2, 2'd1, 2'd0, 2'd3, 2'd2};
  localparam logic             T_LONG [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic             T_RR   [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic [SRC_W-1:0] T_PEND [NV] = '{8'h2C, 8'h80, 8'h05, 8'h01, 8'h41, 8'h60};
  localparam logic [PC_W-1:0]  T_PC   [NV] = '{22'h3A5C7E, 22'h001234, 22'h0000AB,
                                               22'h000055, 22'h2F0E19, 22'h10C3D2};
  localparam logic [SP_W-1:0]  T_SP   [NV] = '{16'h08FF, 16'h0400, 16'h0100,
                                               16'h0001, 16'h0FF0, 16'h0000};

  logic             clk = 1'b0;
  logic             rst;
  logic [1:0]       cfg_pc_bytes;
  logic             cfg_long_slot;
  logic             reset_req;
  logic [SRC_W-1:0] pend_src;
  logic             gie;
  logic             skip_pend;
  logic [PC_W-1:0]  pc_cur;
  logic [SP_W-1:0]  sp_cur;
  logic             taken, stall, mem_we, pc_load, sp_load, gie_clr, reset_ack, req_drop;
  logic [SP_W-1:0]  mem_addr, sp_new;
  logic [7:0]       mem_wdata;
  logic [PC_W-1:0]  pc_new;
  logic [SRC_W-1:0] src_ack;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_entry_seq #(.SRC_W(SRC_W), .PC_W(PC_W), .SP_W(SP_W)) u_irq_entry_seq (
    .clk, .rst, .cfg_pc_bytes, .cfg_long_slot, .reset_req, .pend_src, .gie,
    .skip_pend, .pc_cur, .sp_cur, .taken, .stall, .mem_we, .mem_addr, .mem_wdata,
    .pc_load, .pc_new, .sp_load, .sp_new, .gie_clr, .src_ack, .reset_ack, .req_drop
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] cfg, input logic lng);
    @(negedge clk);
    rst = 1'b1; cfg_pc_bytes = cfg; cfg_long_slot = lng;
    reset_req = 1'b0; pend_src = '0; gie = 1'b0; skip_pend = 1'b0;
    pc_cur = '0; sp_cur = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic check_quiet(input string req);
    chk(req, "taken", taken, 0);
    chk(req, "stall", stall, 0);
    chk(req, "mem_we", mem_we, 0);
  endtask

  // Run one entry; cfg/lng are the settings captured at the last reset.
  task automatic run_entry(input logic [1:0] cfg, input logic lng, input logic rr,
                           input logic [SRC_W-1:0] pend, input logic [PC_W-1:0] pc,
                           input logic [SP_W-1:0] sp);
    int nb;
    int vec;
    int lo;
    logic [SRC_W-1:0] ack;
    logic [23:0] pcx;
    nb  = (cfg == 2'd3) ? 3 : (cfg == 2'd2) ? 2 : 1;
    lo  = -1;
    for (int i = SRC_W - 1; i >= 0; i--) if (pend[i]) lo = i;
    vec = rr ? 0 : lo + 1;
    ack = rr ? '0 : (SRC_W'(1) << lo);
    pcx = 24'(pc);
    reset_req = rr; pend_src = pend; gie = 1'b1; skip_pend = 1'b0;
    pc_cur = pc; sp_cur = sp;
    @(negedge clk);
    chk("R9", "taken first", taken, 1);
    chk("R9", "stall first", stall, 1);
    for (int k = 0; k < nb; k++) begin
      if (k > 0) begin
        @(negedge clk);
        chk("R9", "taken later", taken, 0);
      end
      chk("R5", "mem_we", mem_we, 1);
      chk("R5", "mem_addr", mem_addr, 32'(SP_W'(sp - SP_W'(k))));
      chk("R5", "mem_wdata", mem_wdata, 32'(pcx[8*k +: 8]));
    end
    @(negedge clk);
    chk("R6", "no extra write", mem_we, 0);
    chk("R7", "pc_load", pc_load, 1);
    chk("R7", "sp_load", sp_load, 1);
    chk("R7", "gie_clr", gie_clr, 1);
    chk("R9", "stall vector", stall, 1);
    chk("R4", "pc_new", pc_new, 32'(vec * (lng ? 2 : 1)));
    chk("R6", "sp_new", sp_new, 32'(SP_W'(sp - SP_W'(nb))));
    chk("R8", "src_ack", src_ack, 32'(ack));
    chk("R8", "reset_ack", reset_ack, 32'(rr));
    chk("R8", "req_drop", req_drop, 32'(!rr && ((pend & ~ack) == '0)));
    gie = 1'b0; reset_req = 1'b0; pend_src = pend & ~ack;
    @(negedge clk);
    chk("R9", "stall end", stall, 0);
    chk("R7", "pc_load single", pc_load, 0);
    chk("R7", "gie_clr single", gie_clr, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    do_reset(2'd3, 1'b1);
    @(negedge clk);
    chk("R11", "taken", taken, 0);
    chk("R11", "stall", stall, 0);
    chk("R11", "mem_we", mem_we, 0);
    chk("R11", "pc_load", pc_load, 0);
    chk("R11", "gie_clr", gie_clr, 0);
    chk("R11", "src_ack", src_ack, 0);

    // R3 R4 R5 R6: table of vectors
    for (int v = 0; v < NV; v++) begin
      do_reset(T_CFG[v], T_LONG[v]);
      run_entry(T_CFG[v], T_LONG[v], T_RR[v], T_PEND[v], T_PC[v], T_SP[v]);
    end

    // R1: skip pending blocks both reset and hardware requests
    do_reset(2'd2, 1'b0);
    reset_req = 1'b1; pend_src = 8'h10; gie = 1'b1; skip_pend = 1'b1;
    pc_cur = 22'h000321; sp_cur = 16'h0200;
    repeat (4) begin
      @(negedge clk);
      check_quiet("R1");
    end
    // R2: once the skip clears, the reset request wins with vector 0
    run_entry(2'd2, 1'b0, 1'b1, 8'h10, 22'h000321, 16'h0200);

    // R2: global enable low blocks acceptance
    pend_src = 8'h08; reset_req = 1'b1; gie = 1'b0; skip_pend = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check_quiet("R2");
    end

    // R10: configuration changes after reset are ignored
    do_reset(2'd1, 1'b0);
    cfg_pc_bytes = 2'd3; cfg_long_slot = 1'b1;
    @(negedge clk);
    run_entry(2'd1, 1'b0, 1'b0, 8'h02, 22'h1ABCDE, 16'h0300);

    // R3: second entry serves the next remaining bit
    run_entry(2'd1, 1'b0, 1'b0, 8'hC0, 22'h000777, 16'h02FF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule